// File: doc/BRIEF.md
# Channel Interrupt Status Aggregator

This block gathers single-cycle interrupt events from a bank of logical DMA channels into status words of one bit per channel and raises interrupt lines towards the host. Each status word has a matching per-channel mask word. A masked channel still records its event in the status word, but it cannot drive a line. With the parameter defaults there are 64 channels and two 32-bit words. The low word holds channels 31..0 and the high word holds channels 63..32.

A control word selects two behaviours. The fold bit chooses how words map to lines. When it is clear, status word *w* drives line *w*. When it is set, every word drives line 0 and the other lines stay low. The software-clear bit chooses how status is cleared. When it is set, the host clears bits by writing ones to a status word. When it is clear, the block clears status automatically: a read of a status word clears exactly the bits that the read returned.

A simple register port gives access to the status, mask and control words. Writes take effect at the clock edge that samples them. Read data appears on the cycle after the read strobe and then holds until the next read.

Top module: `intr_agg`

Register map (word addresses, default parameters): status word *w* sits at *w* (0, 1), mask word *w* sits at 2+*w* (2, 3), and the control word sits at 4. Control bit 0 is fold and control bit 1 is software-clear. The other control bits read as 0.

## Requirements
- R1: After reset, every status, mask and control bit is 0, both interrupt lines are low, and read data is 0.
- R2: A pulse on event input *c* sets bit *c* mod 32 of status word *c* / 32 at the next clock edge. The bit stays set until it is cleared. The mask has no effect on this.
- R3: A line is the OR of its status bits ANDed with their mask bits. A mask bit of 1 lets the channel through and a mask bit of 0 blocks it.
- R4: With control bit 0 (fold) at 0, word 0 drives line 0 and word 1 drives line 1.
- R5: With fold at 1, both words drive line 0, and line 1 stays low.
- R6: With control bit 1 (software-clear) at 1, writing a status word clears the bits written as 1 and keeps the bits written as 0. Reads do not clear.
- R7: With software-clear at 0, a read of a status word clears exactly the bits it returned. An event arriving in the same cycle stays set. The other word is not affected.
- R8: In software-clear mode, an event on a channel in the same cycle as a write of 1 to that channel's status bit leaves the bit set.
- R9: With software-clear at 0, writes to a status word have no effect.
- R10: Read data appears one cycle after the read strobe and holds between reads. Mask words read back as written. The control word reads back as its two bits. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_i | input | NUM_CH (64) | One-cycle event pulse per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W (3) | Register word address |
| reg_wdata_i | input | WORD_W (32) | Write data |
| reg_rdata_o | output | WORD_W (32) | Read data, registered |
| irq_o | output | NUM_WORDS (2) | Interrupt lines |

## Verification
A status bit that fails to set, or that sets on the wrong channel, shows on the next cycle. The line in that channel's word rises, stays low, or lands on the wrong line, depending on the mask and fold settings. The following status read then returns the wrong word. A clear policy that is wrong shows up on the second read: the bits still there, or gone, do not match the first read. The sweep drives every channel under all four fold and clear combinations, using both a lone-unmasked mask and a lone-masked mask. The bench predicts every line and every readback from a plain bit-vector model.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;

    // Control word field positions (other bits read as zero)
    localparam int CTRL_FOLD_POS  = 0;
    localparam int CTRL_SWCLR_POS = 1;

    typedef struct packed {
        logic swclr;   // bit 1: 1 = write-one-to-clear, 0 = clear-on-read
        logic fold;    // bit 0: 1 = every word drives line 0
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MASK,
        SEL_CTRL
    } reg_sel_e;

endpackage

// File: rtl/intr_stat_word.sv
module intr_stat_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic         w1c_en_i,
    input  logic [W-1:0] w1c_mask_i,
    input  logic         rdclr_en_i,
    output logic [W-1:0] stat_o
);

    logic [W-1:0] stat_q;
    logic [W-1:0] clr;
    logic [W-1:0] stat_d;

    // Clearing never wins over a new event on the same bit
    always_comb begin
        if (w1c_en_i) begin
            clr = w1c_mask_i;
        end else if (rdclr_en_i) begin
            clr = stat_q;
        end else begin
            clr = '0;
        end
        stat_d = (stat_q & ~clr) | ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/intr_cfg_regs.sv
module intr_cfg_regs
    import intr_agg_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  reg_sel_e                      sel_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [WORD_W-1:0]             wdata_i,
    output logic [NUM_WORDS*WORD_W-1:0]   mask_o,
    output ctrl_t                         ctrl_o
);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mask
        logic [WORD_W-1:0] mask_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q <= '0;
            end else if (wr_en_i && sel_i == SEL_MASK && idx_i == IDX_W'(w)) begin
                mask_q <= wdata_i;
            end
        end
        assign mask_o[w*WORD_W +: WORD_W] = mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o <= '0;
        end else if (wr_en_i && sel_i == SEL_CTRL) begin
            ctrl_o.fold  <= wdata_i[CTRL_FOLD_POS];
            ctrl_o.swclr <= wdata_i[CTRL_SWCLR_POS];
        end
    end

endmodule

// File: rtl/intr_line_route.sv
module intr_line_route #(
    parameter int NUM_WORDS = 2,
    parameter int WORD_W    = 32
) (
    input  logic [NUM_WORDS*WORD_W-1:0] stat_i,
    input  logic [NUM_WORDS*WORD_W-1:0] mask_i,
    input  logic                        fold_i,
    output logic [NUM_WORDS-1:0]        irq_o
);

    logic [NUM_WORDS-1:0] pend;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_pend
        assign pend[w] = |(stat_i[w*WORD_W +: WORD_W] & mask_i[w*WORD_W +: WORD_W]);
    end

    assign irq_o[0] = fold_i ? (|pend) : pend[0];

    for (genvar w = 1; w < NUM_WORDS; w++) begin : g_line
        assign irq_o[w] = fold_i ? 1'b0 : pend[w];
    end

endmodule

// File: rtl/intr_agg.sv
module intr_agg
    import intr_agg_pkg::*;
#(
    parameter int NUM_CH    = 64,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = NUM_CH / WORD_W,
    parameter int ADDR_W    = $clog2(2 * NUM_WORDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    ev_i,
    input  logic                 reg_wr_i,
    input  logic                 reg_rd_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [WORD_W-1:0]    reg_wdata_i,
    output logic [WORD_W-1:0]    reg_rdata_o,
    output logic [NUM_WORDS-1:0] irq_o
);

    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    reg_sel_e                    sel;
    logic [IDX_W-1:0]            idx;
    logic [NUM_CH-1:0]           stat_flat;
    logic [NUM_CH-1:0]           mask_flat;
    ctrl_t                       ctrl;
    logic [WORD_W-1:0]           rd_mux;
    logic [WORD_W-1:0]           rdata_q;

    // Address decode: status words, then mask words, then control
    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (reg_addr_i < ADDR_W'(NUM_WORDS)) begin
            sel = SEL_STAT;
            idx = IDX_W'(reg_addr_i);
        end else if (reg_addr_i < ADDR_W'(2 * NUM_WORDS)) begin
            sel = SEL_MASK;
            idx = IDX_W'(reg_addr_i - ADDR_W'(NUM_WORDS));
        end else if (reg_addr_i == ADDR_W'(2 * NUM_WORDS)) begin
            sel = SEL_CTRL;
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit;
        assign hit = (sel == SEL_STAT) && (idx == IDX_W'(w));

        intr_stat_word #(.W(WORD_W)) u_word (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_i       (ev_i[w*WORD_W +: WORD_W]),
            .w1c_en_i   (reg_wr_i && hit && ctrl.swclr),
            .w1c_mask_i (reg_wdata_i),
            .rdclr_en_i (reg_rd_i && hit && !ctrl.swclr),
            .stat_o     (stat_flat[w*WORD_W +: WORD_W])
        );
    end

    intr_cfg_regs #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (reg_wr_i),
        .sel_i   (sel),
        .idx_i   (idx),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask_flat),
        .ctrl_o  (ctrl)
    );

    intr_line_route #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) u_route (
        .stat_i (stat_flat),
        .mask_i (mask_flat),
        .fold_i (ctrl.fold),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_STAT: rd_mux = stat_flat[idx*WORD_W +: WORD_W];
            SEL_MASK: rd_mux = mask_flat[idx*WORD_W +: WORD_W];
            SEL_CTRL: rd_mux[1:0] = ctrl;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd_i) begin
            rdata_q <= rd_mux;
        end
    end

    assign reg_rdata_o = rdata_q;

endmodule

// File: rtl/intr_agg_chk.sv
module intr_agg_chk #(
    parameter int NUM_CH    = 64,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = NUM_CH / WORD_W,
    parameter int ADDR_W    = $clog2(2 * NUM_WORDS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CH-1:0]    ev_i,
    input logic [NUM_CH-1:0]    stat_i,
    input logic [NUM_CH-1:0]    mask_i,
    input logic [1:0]           ctrl_i,
    input logic                 reg_rd_i,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic [WORD_W-1:0]    reg_rdata_o,
    input logic [NUM_WORDS-1:0] irq_o
);

    // R2: every pulsed channel is recorded at the next edge
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((stat_i & $past(ev_i)) == $past(ev_i)));

    // R2: a status bit never rises without an event
    a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & ~$past(stat_i) & ~$past(ev_i)) == '0));

    // R3: with every channel masked no line is raised
    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> (irq_o == '0));

    // R5: fold keeps the upper lines low
    a_r5_fold_upper_low: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i[0] |-> (irq_o[NUM_WORDS-1:1] == '0));

    // R7: clear-on-read of word 0 leaves only same-cycle events
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && !ctrl_i[1] && reg_addr_i == '0)
        |=> ((stat_i[WORD_W-1:0] & ~$past(ev_i[WORD_W-1:0])) == '0));

    // R7: the read returns the word as it stood before the clear
    a_r7_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == '0)
        |=> (reg_rdata_o == $past(stat_i[WORD_W-1:0])));

    // R10: read data holds between reads
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> $stable(reg_rdata_o));

endmodule

bind intr_agg intr_agg_chk #(
    .NUM_CH    (NUM_CH),
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_i        (ev_i),
    .stat_i      (stat_flat),
    .mask_i      (mask_flat),
    .ctrl_i      (ctrl),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
);

// File: tb/tb_intr_agg.sv
module tb_intr_agg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ev = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  irq;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    intr_agg dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [63:0] e);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; ev = e;
        @(negedge clk);
        reg_wr = 1'b0; ev = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d, input logic [63:0] e);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a; ev = e;
        @(negedge clk);
        reg_rd = 1'b0; ev = '0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [63:0] e);
        @(negedge clk);
        ev = e;
        @(negedge clk);
        ev = '0;
    endtask

    function automatic logic [1:0] exp_irq(logic [63:0] s, logic [63:0] m, logic fold);
        logic p0, p1;
        p0 = |(s[31:0] & m[31:0]);
        p1 = |(s[63:32] & m[63:32]);
        return fold ? {1'b0, p0 | p1} : {p1, p0};
    endfunction

    initial begin
        logic [31:0] d;
        logic [63:0] b;
        logic [63:0] msk;
        logic [31:0] wb;
        int          w;
        logic        fold, sw;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq", {62'd0, irq}, 64'd0);
        chk("R1 rdata", {32'd0, reg_rdata}, 64'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d, '0);
            chk("R1 reg", {32'd0, d}, 64'd0);
        end

        // R10: readback and unused addresses
        wr(3'd2, 32'hA5A5_0F0F, '0);
        wr(3'd3, 32'h1234_8001, '0);
        rd(3'd2, d, '0); chk("R10 mask0", {32'd0, d}, 64'hA5A5_0F0F);
        rd(3'd3, d, '0); chk("R10 mask1", {32'd0, d}, 64'h1234_8001);
        @(negedge clk); @(negedge clk);
        chk("R10 hold", {32'd0, reg_rdata}, 64'h1234_8001);
        wr(3'd4, 32'hFFFF_FFFF, '0);
        rd(3'd4, d, '0); chk("R10 ctrl", {32'd0, d}, 64'd3);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), d, '0);
            chk("R10 unused", {32'd0, d}, 64'd0);
        end

        // Sweep: every channel under every fold/clear combination
        for (int m = 0; m < 4; m++) begin
            fold = m[0];
            sw   = m[1];
            wr(3'd4, 32'(m), '0);
            for (int c = 0; c < 64; c++) begin
                b   = 64'd1 << c;
                msk = (((c + m) % 2) == 0) ? b : ~b;
                w   = c / 32;
                wb  = 32'd1 << (c % 32);
                wr(3'd2, msk[31:0], '0);
                wr(3'd3, msk[63:32], '0);
                pulse(b);
                chk(fold ? "R3 R5 line" : "R3 R4 line", {62'd0, irq}, {62'd0, exp_irq(b, msk, fold)});
                rd(3'(w), d, '0);
                chk("R2 set", {32'd0, d}, {32'd0, wb});
                rd(3'(1 - w), d, '0);
                chk("R2 other word", {32'd0, d}, 64'd0);
                if (sw) begin
                    rd(3'(w), d, '0);
                    chk("R6 read keeps", {32'd0, d}, {32'd0, wb});
                    wr(3'(w), ~wb, '0);
                    rd(3'(w), d, '0);
                    chk("R6 zero keeps", {32'd0, d}, {32'd0, wb});
                    wr(3'(w), wb, '0);
                end
                rd(3'(w), d, '0);
                chk(sw ? "R6 cleared" : "R7 cleared", {32'd0, d}, 64'd0);
                chk("R3 line low", {62'd0, irq}, 64'd0);
            end
        end

        // R3: status kept while masked, line rises on unmask
        wr(3'd4, 32'd2, '0);
        wr(3'd2, 32'd0, '0);
        wr(3'd3, 32'd0, '0);
        pulse(64'h0000_0001_0000_0000);
        chk("R3 masked", {62'd0, irq}, 64'd0);
        wr(3'd3, 32'd1, '0);
        chk("R3 unmasked", {62'd0, irq}, 64'd2);
        wr(3'd1, 32'd1, '0);
        chk("R3 cleared", {62'd0, irq}, 64'd0);

        // R8: event and write-one-to-clear on the same bit
        pulse(64'd1 << 7);
        wr(3'd0, 32'd1 << 7, 64'd1 << 7);
        rd(3'd0, d, '0); chk("R8 collision", {32'd0, d}, 64'h80);
        wr(3'd0, 32'd1 << 7, '0);
        rd(3'd0, d, '0); chk("R8 clear", {32'd0, d}, 64'd0);

        // R7: event during a clearing read
        wr(3'd4, 32'd0, '0);
        pulse(64'h28);
        rd(3'd0, d, 64'h08); chk("R7 returned", {32'd0, d}, 64'h28);
        rd(3'd0, d, '0);     chk("R7 kept event", {32'd0, d}, 64'h08);
        rd(3'd0, d, '0);     chk("R7 empty", {32'd0, d}, 64'd0);
        pulse(64'd1 << 40);
        rd(3'd0, d, '0);     chk("R7 word0", {32'd0, d}, 64'd0);
        rd(3'd1, d, '0);     chk("R7 word1 untouched", {32'd0, d}, 64'h100);

        // R9: writes ignored in clear-on-read mode
        wr(3'd2, 32'h4, '0);
        pulse(64'h4);
        wr(3'd0, 32'hFFFF_FFFF, '0);
        chk("R9 line", {62'd0, irq}, 64'd1);
        rd(3'd0, d, '0); chk("R9 status", {32'd0, d}, 64'h4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule